// File: doc/BRIEF.md
# Daisy-Chain Bring-Up Sequencer

This block is the host-side controller that brings a string of hashing chips, daisy-chained on one SPI bus, out of hardware reset and into a known state. On a start pulse it drives the shared active-low chip reset low for a fixed number of cycles, releases it, and waits a second fixed interval. It then runs three broadcast initialization stages in a fixed order: reset, self-test start, self-test fix. Each stage sends its command word once and then sends filler words until the expected reply comes back or a poll budget runs out.

The reply to the self-test start carries the number of chips in the chain in its low byte. The block keeps that count and reports it. After the last stage it raises done. It then accepts register read requests addressed to one chip, but only when the address is between one and the enumerated count. Enumeration is never repeated on a live chain: every start begins with a fresh hardware reset.

The block works at word level. A separate shifter takes each 16-bit command word through a valid/ready handshake and returns exactly one 16-bit reply word per accepted word.

Top module: `chain_bringup_seq`

## Requirements
- R1: After `rst_n` is released and before any start, `chip_rst_n_o` is 0, and `cmd_valid_o`, `done_o`, `err_o`, `rd_valid_o` and `rd_reject_o` are 0, with `chip_count_o` at 0.
- R2: After an accepted start, `chip_rst_n_o` is 0 for exactly HOLD_CYC cycles and then 1. The first command word appears exactly SETTLE_CYC cycles after the release, and no command word is presented while the chip reset is low.
- R3: Stages run in the order reset, self-test start, self-test fix. Each stage sends its command word once (0x0400, 0x0100, 0x0300), followed by filler words 0x0000, one per returned reply, until a reply matches. The reset stage matches only 0x0400, the self-test start stage matches any reply whose upper byte is 0x01, and the fix stage matches only 0x0300.
- R4: The low byte of the matching self-test start reply appears on `chip_count_o`. An accepted start clears the count to 0.
- R5: A matching self-test start reply with a low byte of 0 ends the run with `err_o` = 1 and `err_stage_o` = 5, and no 0x0300 word is sent.
- R6: When POLL_LIMIT words have been sent in one stage without a matching reply, `err_o` rises and `err_stage_o` names the stage: 1 reset, 2 self-test start, 3 fix, 4 register read. `done_o` and `err_o` are never 1 together.
- R7: After the fix reply matches, `done_o` stays 1 and `chip_count_o` stays stable until the next start.
- R8: A register read to chip A sends {0x0A, A} and polls with fillers until a reply has upper byte 0x1A. It then sends one more filler, presents that filler's reply on `rd_data_o`, and pulses `rd_valid_o` for one cycle.
- R9: A read request with address 0, with an address above `chip_count_o`, or made while `done_o` is 0, is answered by a one-cycle `rd_reject_o` pulse in the next cycle and sends no command word.
- R10: When start and a read request arrive in the same cycle while `done_o` is 1, the start wins. No reject is given, no read word is sent, and a full hardware reset and re-enumeration follows.
- R11: A start pulse while a run is in progress (hold, settle, or a stage) has no effect on the timing or the words of that run.
- R12: While `cmd_valid_o` is 1 and `cmd_ready_i` is 0, `cmd_valid_o` stays 1 and `cmd_word_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a bring-up run (acted on when idle, done or failed) |
| done_o | output | 1 | Chain initialized; reads may be requested |
| err_o | output | 1 | Run ended in an error |
| err_stage_o | output | 3 | Failing stage code (1 reset, 2 self-test, 3 fix, 4 read, 5 empty chain) |
| chip_rst_n_o | output | 1 | Active-low hardware reset to the chain |
| cmd_valid_o | output | 1 | Command word is valid |
| cmd_ready_i | input | 1 | Shifter accepts the command word |
| cmd_word_o | output | 16 | Command word to shift out |
| rsp_valid_i | input | 1 | Reply word is valid (one per accepted command word) |
| rsp_word_i | input | 16 | Reply word shifted in |
| rd_req_i | input | 1 | Register read request |
| rd_addr_i | input | 8 | Chip address for the read |
| rd_reject_o | output | 1 | One-cycle pulse: read request refused |
| rd_valid_o | output | 1 | One-cycle pulse: read data valid |
| rd_data_o | output | 16 | Register contents from the addressed chip |
| chip_count_o | output | 8 | Number of chips found by enumeration |

## Verification
A start and a register read request can both arrive in the same cycle while the block reports done. The bench drives both lines high for one cycle. It judges the outcome at the ports: no reject pulse, the chip reset held low for the full hold period, and the scoreboard receiving the reset-stage words rather than a read word. A second collision, a start pulse during the hold of a run already under way, is judged by the hold still lasting exactly HOLD_CYC cycles and by the run's word stream staying unchanged.

// File: rtl/chain_seq_pkg.sv
package chain_seq_pkg;

  typedef enum logic [2:0] {
    STG_NONE  = 3'd0,
    STG_RESET = 3'd1,
    STG_BIST  = 3'd2,
    STG_FIX   = 3'd3,
    STG_READ  = 3'd4,
    STG_EMPTY = 3'd5,
    STG_DATA  = 3'd6
  } stage_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HOLD,
    S_SETTLE,
    S_ISSUE,
    S_AWAIT,
    S_READY,
    S_FAIL
  } seq_state_e;

  localparam logic [7:0]  OP_RESET    = 8'h04;
  localparam logic [7:0]  OP_BIST     = 8'h01;
  localparam logic [7:0]  OP_FIX      = 8'h03;
  localparam logic [7:0]  OP_RDREG    = 8'h0A;
  localparam logic [7:0]  REPLY_RDREG = 8'h1A;
  localparam logic [15:0] FILLER_WORD = 16'h0000;

endpackage

// File: rtl/cs_delay_timer.sv
module cs_delay_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)           cnt_d = load_val_i;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/cs_poll_ctr.sv
module cs_poll_ctr #(
  parameter int LIMIT = 4,
  parameter int W     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic inc_i,
  output logic at_limit_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)                   cnt_d = '0;
    else if (inc_i && cnt_q != '1) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign at_limit_o = (cnt_q >= W'(LIMIT));
endmodule

// File: rtl/cs_reply_check.sv
module cs_reply_check
  import chain_seq_pkg::*;
(
  input  stage_e      stage_i,
  input  logic [15:0] word_i,
  output logic        hit_o,
  output logic        low_zero_o
);
  always_comb begin
    case (stage_i)
      STG_RESET: hit_o = (word_i == {OP_RESET, 8'h00});
      STG_BIST:  hit_o = (word_i[15:8] == OP_BIST);
      STG_FIX:   hit_o = (word_i == {OP_FIX, 8'h00});
      STG_READ:  hit_o = (word_i[15:8] == REPLY_RDREG);
      STG_DATA:  hit_o = 1'b1;
      default:   hit_o = 1'b0;
    endcase
  end

  assign low_zero_o = (word_i[7:0] == 8'h00);
endmodule

// File: rtl/chain_bringup_seq.sv
module chain_bringup_seq
  import chain_seq_pkg::*;
#(
  parameter int HOLD_CYC   = 1000000,
  parameter int SETTLE_CYC = 1000000,
  parameter int POLL_LIMIT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  output logic        done_o,
  output logic        err_o,
  output logic [2:0]  err_stage_o,
  output logic        chip_rst_n_o,
  output logic        cmd_valid_o,
  input  logic        cmd_ready_i,
  output logic [15:0] cmd_word_o,
  input  logic        rsp_valid_i,
  input  logic [15:0] rsp_word_i,
  input  logic        rd_req_i,
  input  logic [7:0]  rd_addr_i,
  output logic        rd_reject_o,
  output logic        rd_valid_o,
  output logic [15:0] rd_data_o,
  output logic [7:0]  chip_count_o
);
  localparam int TMR_MAX = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int POLL_W  = $clog2(POLL_LIMIT + 2);
  localparam logic [TMR_W-1:0] HOLD_LOAD   = TMR_W'(HOLD_CYC - 1);
  localparam logic [TMR_W-1:0] SETTLE_LOAD = TMR_W'(SETTLE_CYC - 1);

  seq_state_e  state_q, state_d;
  stage_e      stage_q, stage_d;
  logic [15:0] tx_word_q, tx_word_d;
  logic [7:0]  count_q, count_d;
  logic [15:0] rd_data_q, rd_data_d;
  logic        rd_valid_q, rd_valid_d;
  logic        rd_reject_q, rd_reject_d;
  logic [2:0]  err_stage_q, err_stage_d;

  logic             tmr_load, tmr_expired;
  logic [TMR_W-1:0] tmr_val;
  logic             poll_clr, poll_inc, poll_at_limit;
  logic             rsp_hit, rsp_low_zero;
  logic             restart_ok, take_start;

  cs_delay_timer #(.W(TMR_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_expired)
  );

  cs_poll_ctr #(.LIMIT(POLL_LIMIT), .W(POLL_W)) u_poll (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (poll_clr),
    .inc_i      (poll_inc),
    .at_limit_o (poll_at_limit)
  );

  cs_reply_check u_match (
    .stage_i    (stage_q),
    .word_i     (rsp_word_i),
    .hit_o      (rsp_hit),
    .low_zero_o (rsp_low_zero)
  );

  assign restart_ok = (state_q == S_IDLE) || (state_q == S_READY) || (state_q == S_FAIL);
  assign take_start = start_i && restart_ok;

  // Next-state process
  always_comb begin
    state_d     = state_q;
    stage_d     = stage_q;
    tx_word_d   = tx_word_q;
    count_d     = count_q;
    rd_data_d   = rd_data_q;
    err_stage_d = err_stage_q;
    rd_valid_d  = 1'b0;
    rd_reject_d = 1'b0;
    tmr_load    = 1'b0;
    tmr_val     = HOLD_LOAD;
    poll_clr    = 1'b0;
    poll_inc    = 1'b0;

    if (take_start) begin
      state_d     = S_HOLD;
      stage_d     = STG_NONE;
      count_d     = 8'h00;
      err_stage_d = STG_NONE;
      tmr_load    = 1'b1;
      tmr_val     = HOLD_LOAD;
    end else begin
      case (state_q)
        S_HOLD: begin
          if (tmr_expired) begin
            state_d  = S_SETTLE;
            tmr_load = 1'b1;
            tmr_val  = SETTLE_LOAD;
          end
        end
        S_SETTLE: begin
          if (tmr_expired) begin
            state_d   = S_ISSUE;
            stage_d   = STG_RESET;
            tx_word_d = {OP_RESET, 8'h00};
            poll_clr  = 1'b1;
          end
        end
        S_ISSUE: begin
          if (cmd_ready_i) begin
            state_d  = S_AWAIT;
            poll_inc = 1'b1;
          end
        end
        S_AWAIT: begin
          if (rsp_valid_i) begin
            if (rsp_hit) begin
              case (stage_q)
                STG_RESET: begin
                  state_d   = S_ISSUE;
                  stage_d   = STG_BIST;
                  tx_word_d = {OP_BIST, 8'h00};
                  poll_clr  = 1'b1;
                end
                STG_BIST: begin
                  if (rsp_low_zero) begin
                    state_d     = S_FAIL;
                    err_stage_d = STG_EMPTY;
                  end else begin
                    state_d   = S_ISSUE;
                    stage_d   = STG_FIX;
                    count_d   = rsp_word_i[7:0];
                    tx_word_d = {OP_FIX, 8'h00};
                    poll_clr  = 1'b1;
                  end
                end
                STG_FIX: state_d = S_READY;
                STG_READ: begin
                  state_d   = S_ISSUE;
                  stage_d   = STG_DATA;
                  tx_word_d = FILLER_WORD;
                  poll_clr  = 1'b1;
                end
                STG_DATA: begin
                  state_d    = S_READY;
                  rd_data_d  = rsp_word_i;
                  rd_valid_d = 1'b1;
                end
                default: state_d = S_FAIL;
              endcase
            end else if (poll_at_limit) begin
              state_d     = S_FAIL;
              err_stage_d = stage_q;
            end else begin
              state_d   = S_ISSUE;
              tx_word_d = FILLER_WORD;
            end
          end
        end
        S_READY: begin
          if (rd_req_i) begin
            if (rd_addr_i == 8'h00 || rd_addr_i > count_q) begin
              rd_reject_d = 1'b1;
            end else begin
              state_d   = S_ISSUE;
              stage_d   = STG_READ;
              tx_word_d = {OP_RDREG, rd_addr_i};
              poll_clr  = 1'b1;
            end
          end
        end
        default: state_d = state_q;
      endcase
      if (rd_req_i && state_q != S_READY) rd_reject_d = 1'b1;
    end
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      stage_q     <= STG_NONE;
      tx_word_q   <= 16'h0000;
      count_q     <= 8'h00;
      rd_data_q   <= 16'h0000;
      rd_valid_q  <= 1'b0;
      rd_reject_q <= 1'b0;
      err_stage_q <= 3'd0;
    end else begin
      state_q     <= state_d;
      stage_q     <= stage_d;
      tx_word_q   <= tx_word_d;
      count_q     <= count_d;
      rd_data_q   <= rd_data_d;
      rd_valid_q  <= rd_valid_d;
      rd_reject_q <= rd_reject_d;
      err_stage_q <= err_stage_d;
    end
  end

  assign chip_rst_n_o = (state_q != S_IDLE) && (state_q != S_HOLD);
  assign cmd_valid_o  = (state_q == S_ISSUE);
  assign cmd_word_o   = tx_word_q;
  assign done_o       = (state_q == S_READY);
  assign err_o        = (state_q == S_FAIL);
  assign err_stage_o  = err_stage_q;
  assign chip_count_o = count_q;
  assign rd_data_o    = rd_data_q;
  assign rd_valid_o   = rd_valid_q;
  assign rd_reject_o  = rd_reject_q;
endmodule

// File: rtl/chain_bringup_seq_chk.sv
module chain_bringup_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        done_o,
  input logic        err_o,
  input logic [2:0]  err_stage_o,
  input logic        chip_rst_n_o,
  input logic        cmd_valid_o,
  input logic        cmd_ready_i,
  input logic [15:0] cmd_word_o,
  input logic        rd_valid_o,
  input logic [7:0]  chip_count_o
);
  p_quiet_in_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_rst_n_o |-> !cmd_valid_o);

  p_word_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_word_o)));

  p_count_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> $stable(chip_count_o));

  p_nonzero_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (chip_count_o != 8'h00));

  p_done_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  p_err_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (err_stage_o != 3'd0));

  p_rdv_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |=> !rd_valid_o);
endmodule

bind chain_bringup_seq chain_bringup_seq_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .done_o       (done_o),
  .err_o        (err_o),
  .err_stage_o  (err_stage_o),
  .chip_rst_n_o (chip_rst_n_o),
  .cmd_valid_o  (cmd_valid_o),
  .cmd_ready_i  (cmd_ready_i),
  .cmd_word_o   (cmd_word_o),
  .rd_valid_o   (rd_valid_o),
  .chip_count_o (chip_count_o)
);

// File: tb/chain_bringup_seq_tb_top.sv
module chain_bringup_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 5;
  localparam int SETTLE     = 4;
  localparam int POLLS      = 4;

  logic        clk, rst_n, start_i;
  logic        done_o, err_o, chip_rst_n_o, cmd_valid_o, cmd_ready_i;
  logic [2:0]  err_stage_o;
  logic [15:0] cmd_word_o, rsp_word_i, rd_data_o;
  logic        rsp_valid_i, rd_req_i, rd_reject_o, rd_valid_o;
  logic [7:0]  rd_addr_i, chip_count_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [15:0] exp_q[$];
  logic [15:0] rsp_q[$];

  chain_bringup_seq #(.HOLD_CYC(HOLD), .SETTLE_CYC(SETTLE), .POLL_LIMIT(POLLS)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o), .err_o(err_o),
    .err_stage_o(err_stage_o), .chip_rst_n_o(chip_rst_n_o), .cmd_valid_o(cmd_valid_o),
    .cmd_ready_i(cmd_ready_i), .cmd_word_o(cmd_word_o), .rsp_valid_i(rsp_valid_i),
    .rsp_word_i(rsp_word_i), .rd_req_i(rd_req_i), .rd_addr_i(rd_addr_i),
    .rd_reject_o(rd_reject_o), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .chip_count_o(chip_count_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Scoreboard monitor and chain responder: one reply per accepted word
  initial begin
    int pend;
    pend = 0;
    rsp_valid_i = 1'b0;
    rsp_word_i  = 16'h0000;
    cmd_ready_i = 1'b1;
    forever begin
      @(negedge clk);
      rsp_valid_i = 1'b0;
      cmd_ready_i = ~cmd_ready_i;
      if (pend != 0) begin
        pend--;
        if (pend == 0) begin
          rsp_valid_i = 1'b1;
          if (rsp_q.size() != 0) rsp_word_i = rsp_q.pop_front();
          else                   rsp_word_i = 16'h0000;
        end
      end
      if (rst_n && cmd_valid_o && cmd_ready_i) begin
        if (exp_q.size() == 0) check("R3", "unexpected command word", {16'h0, cmd_word_o}, 32'hFFFF_FFFF);
        else check("R3", "command word", {16'h0, cmd_word_o}, {16'h0, exp_q.pop_front()});
        pend = 2;
      end
    end
  end

  // Driver helpers: push expected words and scripted replies
  task automatic expect_cmds(input logic [15:0] w[]);
    foreach (w[i]) exp_q.push_back(w[i]);
  endtask
  task automatic give_replies(input logic [15:0] w[]);
    foreach (w[i]) rsp_q.push_back(w[i]);
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic measure(input string req);
    int n, m;
    n = 0;
    while (!chip_rst_n_o && n < 100) begin n++; @(negedge clk); end
    check(req, "chip reset low cycles", n, HOLD);
    m = 0;
    while (!cmd_valid_o && m < 100) begin m++; @(negedge clk); end
    check("R2", "release-to-first-word cycles", m, SETTLE);
  endtask

  task automatic wait_end();
    int t;
    t = 0;
    while (!(done_o || err_o) && t < 500) begin t++; @(negedge clk); end
  endtask

  task automatic req_read(input logic [7:0] a);
    rd_addr_i = a;
    rd_req_i  = 1'b1;
    @(negedge clk);
    rd_req_i  = 1'b0;
  endtask

  task automatic wait_rdv();
    int t;
    t = 0;
    while (!rd_valid_o && t < 200) begin t++; @(negedge clk); end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; rd_req_i = 1'b0; rd_addr_i = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check("R1", "chip_rst_n", chip_rst_n_o, 0);
    check("R1", "cmd_valid", cmd_valid_o, 0);
    check("R1", "done/err", {done_o, err_o}, 0);
    check("R1", "rd pulses", {rd_valid_o, rd_reject_o}, 0);
    check("R1", "count", chip_count_o, 0);

    // Phase A: bring-up with one mismatch in each of the first two stages
    expect_cmds('{16'h0400, 16'h0000, 16'h0100, 16'h0000, 16'h0300});
    give_replies('{16'hFFFF, 16'h0400, 16'h0000, 16'h0103, 16'h0300});
    pulse_start();
    measure("R2");
    wait_end();
    check("R7", "done after fix", done_o, 1);
    check("R4", "chip count", chip_count_o, 8'h03);
    check("R3", "all words issued", exp_q.size(), 0);
    repeat (4) @(negedge clk);
    check("R7", "done held", done_o, 1);

    // Phase B: register reads
    expect_cmds('{16'h0A02, 16'h0000, 16'h0000});
    give_replies('{16'hFFFF, 16'h1A02, 16'hBEEF});
    req_read(8'h02);
    check("R9", "no reject on valid read", rd_reject_o, 0);
    wait_rdv();
    check("R8", "read data chip 2", {rd_valid_o, rd_data_o}, {1'b1, 16'hBEEF});
    @(negedge clk);
    check("R8", "rd_valid one cycle", rd_valid_o, 0);
    expect_cmds('{16'h0A03, 16'h0000});
    give_replies('{16'h1A03, 16'h5A5A});
    req_read(8'h03);
    wait_rdv();
    check("R8", "read data chip 3 (count boundary)", {rd_valid_o, rd_data_o}, {1'b1, 16'h5A5A});
    repeat (2) @(negedge clk);
    req_read(8'h00);
    check("R9", "reject broadcast address", rd_reject_o, 1);
    @(negedge clk);
    check("R9", "reject pulse one cycle", rd_reject_o, 0);
    req_read(8'h04);
    check("R9", "reject address above count", rd_reject_o, 1);
    repeat (3) @(negedge clk);
    check("R9", "no word after rejects", exp_q.size(), 0);
    check("R9", "still done after rejects", done_o, 1);
    check("R7", "count unchanged", chip_count_o, 8'h03);

    // Phase C: start and read in the same cycle; empty chain reply
    expect_cmds('{16'h0400, 16'h0100});
    give_replies('{16'h0400, 16'h0100});
    start_i = 1'b1; rd_req_i = 1'b1; rd_addr_i = 8'h01;
    @(negedge clk);
    start_i = 1'b0; rd_req_i = 1'b0;
    check("R10", "no reject when start wins", rd_reject_o, 0);
    check("R4", "count cleared by start", chip_count_o, 0);
    measure("R10");
    wait_end();
    repeat (6) @(negedge clk);
    check("R5", "err on empty chain", {err_o, err_stage_o}, {1'b1, 3'd5});
    check("R5", "done low", done_o, 0);
    check("R5", "no fix word sent", exp_q.size(), 0);

    // Phase D: reset stage timeout; read during busy rejected
    expect_cmds('{16'h0400, 16'h0000, 16'h0000, 16'h0000});
    pulse_start();
    req_read(8'h01);
    check("R9", "reject while busy", rd_reject_o, 1);
    wait_end();
    repeat (6) @(negedge clk);
    check("R6", "reset stage timeout", {err_o, err_stage_o}, {1'b1, 3'd1});
    check("R6", "poll words used", exp_q.size(), 0);

    // Phase E: start pulse during hold ignored; fix stage timeout
    expect_cmds('{16'h0400, 16'h0100, 16'h0300, 16'h0000, 16'h0000, 16'h0000});
    give_replies('{16'h0400, 16'h0102});
    pulse_start();
    begin
      int n;
      n = 0;
      while (!chip_rst_n_o && n < 100) begin
        n++;
        start_i = (n == 2);
        @(negedge clk);
      end
      start_i = 1'b0;
      check("R11", "hold length with extra start", n, HOLD);
    end
    wait_end();
    repeat (6) @(negedge clk);
    check("R6", "fix stage timeout", {err_o, err_stage_o}, {1'b1, 3'd3});
    check("R4", "count captured before fix", chip_count_o, 8'h02);
    check("R11", "word stream unchanged", exp_q.size(), 0);

    // Phase F: good bring-up with one chip, then read timeout
    expect_cmds('{16'h0400, 16'h0100, 16'h0300});
    give_replies('{16'h0400, 16'h0101, 16'h0300});
    pulse_start();
    measure("R2");
    wait_end();
    check("R7", "done single chip", {done_o, chip_count_o}, {1'b1, 8'h01});
    expect_cmds('{16'h0A01, 16'h0000, 16'h0000, 16'h0000});
    req_read(8'h01);
    wait_end();
    repeat (2) @(negedge clk);
    wait_end();
    repeat (6) @(negedge clk);
    check("R6", "read timeout", {err_o, err_stage_o, done_o}, {1'b1, 3'd4, 1'b0});
    check("R6", "read poll words", exp_q.size(), 0);

    finish_run();
  end
endmodule